// File: doc/BRIEF.md
# Tamper Event Latch with Battery-Qualified Monitoring

This block captures an active-high tamper signal, for example from a cover switch, into a sticky status bit. It raises a level interrupt from that bit. The latch runs from the always-on battery domain, so it keeps recording events while main power is off. The interrupt stays masked until the main-power-good input is high again. Software clears the status by writing 1 to a clear bit and then writing 0 to release it.

Monitoring depends on the battery. When the measured battery value is below its programmed low limit, new events are not recorded, and a bit that is already set is kept. The tamper input is asynchronous. It passes through a synchronizer, and the latch responds to its level, not to an edge.

Top module: `intrusion_latch`

## Requirements
- R1: During and after reset, with no further stimulus, `status_o` and `irq_o` are 0 and the clear bit is 0.
- R2: If `tamper_i` is sampled high at rising edge k and stays high, and monitoring is enabled and the clear bit is 0, then `status_o` is 1 after edge k+2 (two synchronizer stages plus the latch).
- R3: Once set, `status_o` stays 1 after `tamper_i` returns low, until a clear.
- R4: A write (`cfg_we_i`=1) with `cfg_clr_i`=1 at edge e sets the clear bit, and `status_o` reads 0 after edge e+1.
- R5: While the clear bit is 1, `status_o` stays 0 whatever `tamper_i` does.
- R6: A write with `cfg_clr_i`=0 releases the clear bit. A tamper level that is still high then latches again one edge later.
- R7: Monitoring is enabled when `batt_meas_i >= batt_lim_i` (unsigned). When `batt_meas_i < batt_lim_i`, tamper is ignored. Equality counts as enabled.
- R8: Events are latched while `pwr_good_i` is 0, and `irq_o` stays 0 while `pwr_good_i` is 0.
- R9: `irq_o` is 1 exactly when `status_o` is 1 and `pwr_good_i` is 1. It rises in the same cycle that power returns over a latched event.
- R10: A battery reading that falls below the limit does not clear a bit that is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tamper_i | input | 1 | Asynchronous tamper level, active high |
| pwr_good_i | input | 1 | Main power good; gates the interrupt |
| batt_meas_i | input | BATT_W | Measured battery value |
| batt_lim_i | input | BATT_W | Battery low limit |
| cfg_we_i | input | 1 | Write strobe for the clear bit |
| cfg_clr_i | input | 1 | Write data for the clear bit |
| status_o | output | 1 | Sticky tamper status |
| irq_o | output | 1 | Interrupt level |

## Verification
The bench checks the exact latency from tamper to status. A design with one synchronizer stage too many or too few reports one cycle off. It checks that the clear bit takes priority over a tamper level held high, and that a premature set is reported as a mismatch. The battery comparison is tested at exactly the limit and one below it, which catches a strict-versus-inclusive compare error. The bench drops the battery below the limit after a bit has latched, which exposes a design that wipes the status instead of only blocking new events. Power is cycled over latched events to show whether the interrupt leaks while power is off or fails to appear when power returns.

// File: rtl/intrusion_latch_pkg.sv
package intrusion_latch_pkg;
  localparam int unsigned DEF_BATT_W = 10;
  localparam int unsigned DEF_SYNC_N = 2;

  typedef struct packed {
    logic set;
    logic clr;
  } latch_ctl_t;
endpackage

// File: rtl/il_sync.sv
module il_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) pipe_q[i] <= 1'b0;
          else         pipe_q[i] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) pipe_q[i] <= 1'b0;
          else         pipe_q[i] <= pipe_q[i-1];
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/il_batt_gate.sv
module il_batt_gate #(
  parameter int unsigned BATT_W = 10
) (
  input  logic [BATT_W-1:0] meas_i,
  input  logic [BATT_W-1:0] lim_i,
  output logic              en_o
);
  // inclusive: reading at the limit still monitors
  assign en_o = (meas_i >= lim_i);
endmodule

// File: rtl/il_clr_reg.sv
module il_clr_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   q_o <= 1'b0;
    else if (we_i) q_o <= d_i;
endmodule

// File: rtl/il_latch_core.sv
module il_latch_core
  import intrusion_latch_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  latch_ctl_t ctl_i,
  output logic       q_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        q_o <= 1'b0;
    else if (ctl_i.clr) q_o <= 1'b0;  // clear dominates
    else if (ctl_i.set) q_o <= 1'b1;
endmodule

// File: rtl/intrusion_latch.sv
module intrusion_latch
  import intrusion_latch_pkg::*;
#(
  parameter int unsigned BATT_W = DEF_BATT_W,
  parameter int unsigned SYNC_N = DEF_SYNC_N
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tamper_i,
  input  logic              pwr_good_i,
  input  logic [BATT_W-1:0] batt_meas_i,
  input  logic [BATT_W-1:0] batt_lim_i,
  input  logic              cfg_we_i,
  input  logic              cfg_clr_i,
  output logic              status_o,
  output logic              irq_o
);
  logic       tamper_s;
  logic       mon_en;
  logic       clr_q;
  latch_ctl_t ctl;

  il_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (tamper_i),
    .q_o   (tamper_s)
  );

  il_batt_gate #(.BATT_W(BATT_W)) u_batt (
    .meas_i(batt_meas_i),
    .lim_i (batt_lim_i),
    .en_o  (mon_en)
  );

  il_clr_reg u_clr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (cfg_we_i),
    .d_i   (cfg_clr_i),
    .q_o   (clr_q)
  );

  assign ctl.set = tamper_s & mon_en;
  assign ctl.clr = clr_q;

  il_latch_core u_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ctl_i (ctl),
    .q_o   (status_o)
  );

  // interrupt held back while main power is down
  assign irq_o = status_o & pwr_good_i;
endmodule

// File: rtl/intrusion_latch_chk.sv
module intrusion_latch_chk #(
  parameter int unsigned BATT_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tamper_i,
  input logic              pwr_good_i,
  input logic [BATT_W-1:0] batt_meas_i,
  input logic [BATT_W-1:0] batt_lim_i,
  input logic              cfg_we_i,
  input logic              cfg_clr_i,
  input logic              tamper_s,
  input logic              clr_q,
  input logic              status_o,
  input logic              irq_o
);
  assert_set_on_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tamper_s && (batt_meas_i >= batt_lim_i) && !clr_q) |=> status_o);

  assert_rise_has_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o) |-> $past(tamper_s));

  assert_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o && !clr_q) |=> status_o);

  assert_clear_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_clr_i) |=> ##1 !status_o);

  assert_clear_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |=> !status_o);

  assert_batt_block_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_o && (batt_meas_i < batt_lim_i)) |=> !status_o);

  assert_irq_masked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |-> !irq_o);

  assert_irq_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> status_o);

  assert_irq_on_power_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o && pwr_good_i) |-> irq_o);

  logic unused_ok;
  assign unused_ok = tamper_i ^ cfg_clr_i;
endmodule

bind intrusion_latch intrusion_latch_chk #(.BATT_W(BATT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tamper_i   (tamper_i),
  .pwr_good_i (pwr_good_i),
  .batt_meas_i(batt_meas_i),
  .batt_lim_i (batt_lim_i),
  .cfg_we_i   (cfg_we_i),
  .cfg_clr_i  (cfg_clr_i),
  .tamper_s   (tamper_s),
  .clr_q      (clr_q),
  .status_o   (status_o),
  .irq_o      (irq_o)
);

// File: tb/intrusion_latch_tb.sv
module intrusion_latch_tb;
  localparam int BW = 10;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          tamper_i = 1'b0;
  logic          pwr_good_i = 1'b1;
  logic [BW-1:0] batt_meas_i = 10'd600;
  logic [BW-1:0] batt_lim_i = 10'd400;
  logic          cfg_we_i = 1'b0;
  logic          cfg_clr_i = 1'b0;
  logic          status_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  intrusion_latch #(.BATT_W(BW)) u_dut (.*);

  always #2 clk_i = ~clk_i;

  // reference state built from the requirements
  logic m_s1, m_s2, m_clr, m_st;
  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      m_s1 <= 0; m_s2 <= 0; m_clr <= 0; m_st <= 0;
    end else begin
      m_s1 <= tamper_i;
      m_s2 <= m_s1;
      if (cfg_we_i) m_clr <= cfg_clr_i;
      if (m_clr) m_st <= 0;
      else if (m_s2 && batt_ok(batt_meas_i, batt_lim_i)) m_st <= 1;
    end

  function automatic bit batt_ok(input logic [BW-1:0] m, input logic [BW-1:0] l);
    return m >= l;
  endfunction

  function automatic bit exp_irq(input bit st, input bit pg);
    return st && pg;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  task automatic wr_clr(input bit v);
    cfg_we_i = 1; cfg_clr_i = v;
    tick();
    cfg_we_i = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D7A5));
    tick(2);
    chk("R1", status_o, 0); chk("R1", irq_o, 0);
    rst_ni = 1;
    tick(2);
    chk("R1", status_o, 0); chk("R1", irq_o, 0);

    // R2 latency
    tamper_i = 1;
    tick(); chk("R2", status_o, 0);
    tick(); chk("R2", status_o, 0);
    tick(); chk("R2", status_o, 1); chk("R9", irq_o, 1);
    // R3 sticky
    tamper_i = 0;
    tick(5); chk("R3", status_o, 1);
    // R4 clear timing
    wr_clr(1); chk("R4", status_o, 1);
    tick(); chk("R4", status_o, 0);
    // R5 tamper ignored while clear bit held
    tamper_i = 1;
    tick(6); chk("R5", status_o, 0); chk("R5", irq_o, 0);
    // R6 release relatches
    wr_clr(0); chk("R6", status_o, 0);
    tick(); chk("R6", status_o, 1);
    tamper_i = 0;
    wr_clr(1); wr_clr(0); tick(3);
    chk("R4", status_o, 0);

    // R7 below limit blocks, equal enables
    batt_meas_i = batt_lim_i - 1;
    tamper_i = 1;
    tick(6); chk("R7", status_o, 0);
    batt_meas_i = batt_lim_i;
    tick(); chk("R7", status_o, 1);
    // R10 battery drop keeps latched bit
    tamper_i = 0;
    batt_meas_i = 10'd5;
    tick(4); chk("R10", status_o, 1);
    batt_meas_i = 10'd600;
    wr_clr(1); wr_clr(0); tick(3);

    // R8 detection with power off, R9 interrupt on return
    pwr_good_i = 0;
    tamper_i = 1;
    tick(3); tamper_i = 0;
    tick(2);
    chk("R8", status_o, 1); chk("R8", irq_o, 0);
    pwr_good_i = 1; #1;
    chk("R9", irq_o, 1);
    tick();
    wr_clr(1); wr_clr(0); tick(3);

    // constrained random against the reference
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(99) < 12) tamper_i = ~tamper_i;
      if ($urandom_range(99) < 4) begin cfg_we_i = 1; cfg_clr_i = $urandom_range(1); end
      else cfg_we_i = 0;
      if ($urandom_range(99) < 5) pwr_good_i = ~pwr_good_i;
      if ($urandom_range(99) < 5) batt_meas_i = batt_lim_i + BW'($urandom_range(6)) - BW'(3);
      tick();
      #1;
      if (m_clr) chk("R5", status_o, m_st);
      else if (!batt_ok(batt_meas_i, batt_lim_i)) chk("R7", status_o, m_st);
      else if (!pwr_good_i) chk("R8", status_o, m_st);
      else chk("R2", status_o, m_st);
      chk("R9", irq_o, exp_irq(m_st, pwr_good_i));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule